// File: doc/BRIEF.md
# Windowed Pixel Cluster Finder

This block receives the pixel hits of one event as a stream of column/row coordinates, the last hit carrying an end-of-event flag. It gathers the event into a pending queue and then groups the hits into clusters of touching pixels. A cluster search starts by placing a fixed window of 21 columns by 8 rows on the oldest pending hit. Each pending hit is examined once. Hits that fall inside the window are set in a local bitmap, and hits that fall outside it go back into the queue in their original order.

Clusters are then grown inside the bitmap. The growth starts from a seed pixel and adds one ring of touching neighbours on each clock cycle until a cycle adds nothing. For each cluster the block reports the number of pixels and the sums of their absolute column and row coordinates, so a later stage can compute the centroid. Pixels left in the bitmap form the next clusters of the same window. When the bitmap is empty, a new window is placed on the oldest hit still queued. The last cluster of the event is flagged.

Top module: `pix_cluster_finder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: in_ready is 1 only while the block is gathering an event and its queue of DEPTH entries (default 16) is not full. It stays 0 from the edge that accepts a hit flagged end-of-event until the last cluster of that event has been taken. An event may hold at most DEPTH hits.
- R3: A window is anchored on the oldest pending hit (ac, ar). It covers columns ac to ac+20 and rows lo to lo+7, where lo = ar-4 clamped to the range 0 to 2^ROW_W-8.
- R4: Every pending hit is examined before any growth starts. Out-of-window hits keep their order, and the next window is anchored on the oldest of them.
- R5: Pixels are connected horizontally, vertically and diagonally (8-connectivity). Each growth cycle adds all unselected window pixels that touch the current selection. Growth ends on the first cycle that adds none.
- R6: The first cluster of a window is seeded by the anchor hit. Each later cluster of that window is seeded by the remaining pixel with the lowest index (column offset × 8 + row offset).
- R7: For each cluster, out_count is the number of pixels, and out_sum_col and out_sum_row are the sums of the pixels' absolute column and row coordinates.
- R8: out_eoe is 1 on the last cluster of an event and 0 on all others.
- R9: While out_valid is 1 and out_ready is 0, out_valid and all output fields stay unchanged.
- R10: With n hits queued and g growth cycles (including the final cycle that adds nothing), the first cluster becomes valid 2+n+g clocks after the edge that accepts the end-of-event hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Hit present |
| in_ready | output | 1 | Hit accepted at this edge when in_valid is also 1 |
| in_col | input | COL_W | Hit column |
| in_row | input | ROW_W | Hit row |
| in_eoe | input | 1 | Hit is the last of its event |
| out_valid | output | 1 | Cluster result present |
| out_ready | input | 1 | Result taken at this edge when out_valid is also 1 |
| out_count | output | CNT_W | Pixels in the cluster |
| out_sum_col | output | COL_W+CNT_W | Sum of the pixel columns |
| out_sum_row | output | ROW_W+CNT_W | Sum of the pixel rows |
| out_eoe | output | 1 | Last cluster of the event |

## Verification
The first cluster of an event is due 2+n+g edges after the end-of-event hit is accepted. Each later cluster follows after a load or seed stage plus its own growth cycles. The bench counts clock edges from the accepting edge and checks the exact latency for a single hit (4 edges) and for a three-pixel row seeded at one end (8 edges).

The bench samples all outputs at the falling edge. A cluster counts as taken at the rising edge where both valid and ready were seen high. While out_ready is held low, the bench compares the fields at every falling edge against the values recorded when the hold began.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ANCHOR,
    ST_LOAD,
    ST_SEED,
    ST_GROW,
    ST_EMIT
  } pcf_state_e;
endpackage

// File: rtl/pcf_hit_fifo.sv
module pcf_hit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  assign rdata = mem[rp];
  assign full  = (int'(count) == DEPTH);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/pcf_cluster_sum.sv
module pcf_cluster_sum #(
  parameter int WIN_C = 21,
  parameter int WIN_R = 8,
  parameter int COL_W = 8,
  parameter int ROW_W = 8,
  localparam int NBIT = WIN_C * WIN_R,
  localparam int CNT_W = $clog2(NBIT + 1),
  localparam int SC_W = COL_W + CNT_W,
  localparam int SR_W = ROW_W + CNT_W
) (
  input  logic [NBIT-1:0]  sel,
  input  logic [COL_W-1:0] base_col,
  input  logic [ROW_W-1:0] base_row,
  output logic [CNT_W-1:0] cnt,
  output logic [SC_W-1:0]  sum_col,
  output logic [SR_W-1:0]  sum_row
);
  always_comb begin
    int n, sc, sr;
    n = 0; sc = 0; sr = 0;
    for (int c = 0; c < WIN_C; c++) begin
      for (int r = 0; r < WIN_R; r++) begin
        if (sel[c*WIN_R+r]) begin
          n  = n + 1;
          sc = sc + c;
          sr = sr + r;
        end
      end
    end
    cnt     = CNT_W'(n);
    sum_col = SC_W'(sc + n * int'(base_col));
    sum_row = SR_W'(sr + n * int'(base_row));
  end
endmodule

// File: rtl/pix_cluster_finder.sv
module pix_cluster_finder #(
  parameter int COL_W = 8,
  parameter int ROW_W = 8,
  parameter int WIN_C = 21,
  parameter int WIN_R = 8,
  parameter int DEPTH = 16,
  localparam int NBIT = WIN_C * WIN_R,
  localparam int CNT_W = $clog2(NBIT + 1),
  localparam int SC_W = COL_W + CNT_W,
  localparam int SR_W = ROW_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [COL_W-1:0] in_col,
  input  logic [ROW_W-1:0] in_row,
  input  logic             in_eoe,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W-1:0] out_count,
  output logic [SC_W-1:0]  out_sum_col,
  output logic [SR_W-1:0]  out_sum_row,
  output logic             out_eoe
);
  import pcf_pkg::*;

  localparam int HW     = COL_W + ROW_W;
  localparam int FCW    = $clog2(DEPTH + 1);
  localparam int OFF_W  = $clog2(WIN_R);
  localparam int LO_MAX = (1 << ROW_W) - WIN_R;

  // Lowest window row for an anchor row: centred, clamped to the sensor.
  function automatic int row_base(input int r);
    int b;
    b = r - WIN_R / 2;
    if (b < 0) b = 0;
    if (b > LO_MAX) b = LO_MAX;
    return b;
  endfunction

  // Each pixel set when it or any of its 8 neighbours is set in s.
  function automatic logic [NBIT-1:0] grow_ring(input logic [NBIT-1:0] s);
    logic [NBIT-1:0] g;
    g = '0;
    for (int c = 0; c < WIN_C; c++) begin
      for (int r = 0; r < WIN_R; r++) begin
        for (int dc = -1; dc <= 1; dc++) begin
          for (int dr = -1; dr <= 1; dr++) begin
            if (c + dc >= 0 && c + dc < WIN_C && r + dr >= 0 && r + dr < WIN_R)
              g[c*WIN_R+r] = g[c*WIN_R+r] | s[(c+dc)*WIN_R+(r+dr)];
          end
        end
      end
    end
    return g;
  endfunction

  pcf_state_e       state;
  logic [COL_W-1:0] wcol;
  logic [ROW_W-1:0] wrow_lo;
  logic [OFF_W-1:0] aoff;
  logic             first_seed;
  logic [FCW-1:0]   load_left;
  logic [NBIT-1:0]  avail, sel;

  logic [HW-1:0]    fifo_rdata, fifo_wdata;
  logic [FCW-1:0]   fifo_cnt;
  logic             fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [COL_W-1:0] hd_col;
  logic [ROW_W-1:0] hd_row;
  logic             hd_in_win;
  logic [NBIT-1:0]  hd_bit, ring, seed_vec;
  logic             grow_step, cluster_emit;
  logic [CNT_W-1:0] sum_cnt;
  logic [SC_W-1:0]  sum_c;
  logic [SR_W-1:0]  sum_r;

  assign hd_col = fifo_rdata[HW-1:ROW_W];
  assign hd_row = fifo_rdata[ROW_W-1:0];

  always_comb begin
    int dc, dr;
    dc = int'(hd_col) - int'(wcol);
    dr = int'(hd_row) - int'(wrow_lo);
    hd_in_win = (dc >= 0) && (dc < WIN_C) && (dr >= 0) && (dr < WIN_R);
    hd_bit = hd_in_win ? (NBIT'(1) << (dc * WIN_R + dr)) : '0;
  end

  assign ring         = grow_ring(sel) & avail & ~sel;
  assign grow_step    = (state == ST_GROW) && (ring != '0);
  assign cluster_emit = (state == ST_GROW) && (ring == '0);
  assign seed_vec     = first_seed ? (NBIT'(1) << aoff) : (avail & (~avail + NBIT'(1)));

  assign in_ready   = (state == ST_IDLE) && !fifo_full;
  assign out_valid  = (state == ST_EMIT);
  assign fifo_pop   = (state == ST_LOAD);
  assign fifo_push  = (in_valid && in_ready) || (fifo_pop && !hd_in_win);
  assign fifo_wdata = (state == ST_LOAD) ? fifo_rdata : {in_col, in_row};

  pcf_hit_fifo #(.W(HW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .count(fifo_cnt),
    .full(fifo_full), .empty(fifo_empty)
  );

  pcf_cluster_sum #(.WIN_C(WIN_C), .WIN_R(WIN_R), .COL_W(COL_W), .ROW_W(ROW_W)) u_sum (
    .sel(sel), .base_col(wcol), .base_row(wrow_lo),
    .cnt(sum_cnt), .sum_col(sum_c), .sum_row(sum_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      wcol        <= '0;
      wrow_lo     <= '0;
      aoff        <= '0;
      first_seed  <= 1'b0;
      load_left   <= '0;
      avail       <= '0;
      sel         <= '0;
      out_count   <= '0;
      out_sum_col <= '0;
      out_sum_row <= '0;
      out_eoe     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid && in_ready && in_eoe) state <= ST_ANCHOR;
        ST_ANCHOR: begin
          wcol       <= hd_col;
          wrow_lo    <= ROW_W'(row_base(int'(hd_row)));
          aoff       <= OFF_W'(int'(hd_row) - row_base(int'(hd_row)));
          load_left  <= fifo_cnt;
          first_seed <= 1'b1;
          avail      <= '0;
          state      <= ST_LOAD;
        end
        ST_LOAD: begin
          avail     <= avail | hd_bit;
          load_left <= load_left - FCW'(1);
          if (load_left == FCW'(1)) state <= ST_SEED;
        end
        ST_SEED: begin
          sel        <= seed_vec;
          first_seed <= 1'b0;
          state      <= ST_GROW;
        end
        ST_GROW: begin
          if (ring != '0) begin
            sel <= sel | ring;
          end else begin
            out_count   <= sum_cnt;
            out_sum_col <= sum_c;
            out_sum_row <= sum_r;
            out_eoe     <= ((avail & ~sel) == '0) && fifo_empty;
            avail       <= avail & ~sel;
            state       <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (avail != '0)     state <= ST_SEED;
            else if (!fifo_empty) state <= ST_ANCHOR;
            else                  state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_cluster_finder_chk.sv
module pix_cluster_finder_chk #(
  parameter int NBIT  = 168,
  parameter int CNT_W = 8,
  parameter int SC_W  = 16,
  parameter int SR_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] out_count,
  input logic [SC_W-1:0]  out_sum_col,
  input logic [SR_W-1:0]  out_sum_row,
  input logic             out_eoe,
  input logic             fifo_full,
  input logic             grow_step,
  input logic             cluster_emit
);
  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready);

  p_busy_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_emit_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cluster_emit |=> out_valid);

  p_grow_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grow_step |=> !out_valid);

  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0) && (int'(out_count) <= NBIT));

  p_eoe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eoe) |=> in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_count) &&
      $stable(out_sum_col) && $stable(out_sum_row) && $stable(out_eoe));
endmodule

bind pix_cluster_finder pix_cluster_finder_chk #(
  .NBIT(NBIT), .CNT_W(CNT_W), .SC_W(SC_W), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_count(out_count), .out_sum_col(out_sum_col),
  .out_sum_row(out_sum_row), .out_eoe(out_eoe), .fifo_full(fifo_full),
  .grow_step(grow_step), .cluster_emit(cluster_emit)
);

// File: tb/pix_cluster_finder_bench.sv
module pix_cluster_finder_bench;
  localparam int COL_W = 8, ROW_W = 8, WC = 21, WR = 8, DEPTH = 16;
  localparam int CNT_W = $clog2(WC * WR + 1);
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eoe = 1'b0, out_ready = 1'b0;
  logic [COL_W-1:0] in_col = '0;
  logic [ROW_W-1:0] in_row = '0;
  logic in_ready, out_valid, out_eoe;
  logic [CNT_W-1:0] out_count;
  logic [COL_W+CNT_W-1:0] out_sum_col;
  logic [ROW_W+CNT_W-1:0] out_sum_row;

  pix_cluster_finder u_pix_cluster_finder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_col(in_col), .in_row(in_row), .in_eoe(in_eoe), .out_valid(out_valid),
    .out_ready(out_ready), .out_count(out_count), .out_sum_col(out_sum_col),
    .out_sum_row(out_sum_row), .out_eoe(out_eoe)
  );

  always #2 clk = ~clk;

  int cyc = 0, total = 0, fails = 0, t_acc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ev_c[DEPTH], ev_r[DEPTH];
  int ex_n[32], ex_sc[32], ex_sr[32], ex_last[32], n_exp;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      fails++; total++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, LIMIT);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic int lo_of(input int r);
    int b = r - WR / 2;
    if (b < 0) b = 0;
    if (b > (1 << ROW_W) - WR) b = (1 << ROW_W) - WR;
    return b;
  endfunction

  function automatic bit touch(input int c1, input int r1, input int c2, input int r2);
    return (c1 - c2 <= 1) && (c2 - c1 <= 1) && (r1 - r2 <= 1) && (r2 - r1 <= 1);
  endfunction

  // Reference: windows, seeds and connected components from the requirements.
  task automatic model(input int n);
    int pc[DEPTH], pr[DEPTH], pn, qn, wn, ac, rlo, left, seed, best, key, cnt, sc, sr;
    int wc[DEPTH], wr[DEPTH];
    bit av[DEPTH], ins[DEPTH], first, changed;
    n_exp = 0; pn = n;
    for (int i = 0; i < n; i++) begin pc[i] = ev_c[i]; pr[i] = ev_r[i]; end
    while (pn > 0) begin
      ac = pc[0]; rlo = lo_of(pr[0]); wn = 0; qn = 0;
      for (int i = 0; i < pn; i++) begin
        if (pc[i] >= ac && pc[i] < ac + WC && pr[i] >= rlo && pr[i] < rlo + WR) begin
          wc[wn] = pc[i]; wr[wn] = pr[i]; wn++;
        end else begin
          pc[qn] = pc[i]; pr[qn] = pr[i]; qn++;
        end
      end
      pn = qn;
      for (int i = 0; i < DEPTH; i++) av[i] = (i < wn);
      left = wn; first = 1;
      while (left > 0) begin
        seed = 0;
        if (!first) begin
          best = 1 << 30;
          for (int i = 0; i < wn; i++) begin
            key = (wc[i] - ac) * WR + (wr[i] - rlo);
            if (av[i] && key < best) begin best = key; seed = i; end
          end
        end
        first = 0;
        for (int i = 0; i < DEPTH; i++) ins[i] = (i == seed);
        changed = 1;
        while (changed) begin
          changed = 0;
          for (int j = 0; j < wn; j++)
            if (av[j] && !ins[j])
              for (int k = 0; k < wn; k++)
                if (ins[k] && !ins[j] && touch(wc[j], wr[j], wc[k], wr[k])) begin
                  ins[j] = 1; changed = 1;
                end
        end
        cnt = 0; sc = 0; sr = 0;
        for (int i = 0; i < wn; i++) if (ins[i]) begin
          cnt++; sc += wc[i]; sr += wr[i]; av[i] = 0;
        end
        left -= cnt;
        ex_n[n_exp] = cnt; ex_sc[n_exp] = sc; ex_sr[n_exp] = sr;
        ex_last[n_exp] = (left == 0 && pn == 0);
        n_exp++;
      end
    end
  endtask

  task automatic send(input int n, input bit eoe_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_col = COL_W'(ev_c[i]); in_row = ROW_W'(ev_r[i]);
      in_eoe = eoe_last && (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      t_acc = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eoe = 1'b0;
  endtask

  task automatic drain(input string tag, input int lat_exp);
    int k = 0, hc = 0, hsc = 0, hsr = 0, he = 0;
    bit done = 0, held = 0, seen = 0;
    while (!done) begin
      if (out_valid) begin
        if (!seen && lat_exp > 0) chk(cyc - t_acc == lat_exp, "R10", "latency", cyc - t_acc, lat_exp);
        seen = 1;
        if (held) begin
          chk(int'(out_count) == hc && int'(out_sum_col) == hsc && int'(out_sum_row) == hsr
              && int'(out_eoe) == he, "R9", "held fields", int'(out_count), hc);
        end
        out_ready = (lat_exp > 0) ? 1'b1 : ($urandom % 3 != 0);
        if (out_ready) begin
          chk(!in_ready, "R2", {tag, " in_ready while busy"}, int'(in_ready), 0);
          chk(int'(out_count) == ex_n[k], "R7", {tag, " count"}, int'(out_count), ex_n[k]);
          chk(int'(out_sum_col) == ex_sc[k], "R7", {tag, " col sum"}, int'(out_sum_col), ex_sc[k]);
          chk(int'(out_sum_row) == ex_sr[k], "R7", {tag, " row sum"}, int'(out_sum_row), ex_sr[k]);
          chk(int'(out_eoe) == ex_last[k], "R8", {tag, " eoe"}, int'(out_eoe), ex_last[k]);
          k++; held = 0;
          if (out_eoe || k >= n_exp) done = 1;
        end else begin
          held = 1; hc = out_count; hsc = out_sum_col; hsr = out_sum_row; he = out_eoe;
        end
      end
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(k == n_exp, "R8", {tag, " cluster total"}, k, n_exp);
  endtask

  task automatic run(input string tag, input int n, input int lat_exp);
    model(n);
    send(n, 1'b1);
    drain(tag, lat_exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic bit dup(input int n, input int c, input int r);
    for (int i = 0; i < n; i++) if (ev_c[i] == c && ev_r[i] == r) return 1;
    return 0;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    // R10: single hit, 2+1+1 edges
    ev_c[0] = 40; ev_r[0] = 100;
    run("R10 single", 1, 4);
    // R5/R10: row of three seeded at one end, 2+3+3 edges
    ev_c[0] = 50; ev_r[0] = 60; ev_c[1] = 51; ev_r[1] = 60; ev_c[2] = 52; ev_r[2] = 60;
    run("R5 line", 3, 8);
    // R5: diagonal touch joins, gap of one splits
    ev_c[0] = 10; ev_r[0] = 20; ev_c[1] = 11; ev_r[1] = 21; ev_c[2] = 13; ev_r[2] = 21;
    run("R5 diag", 3, 0);
    // R3: low-edge clamp keeps row 7, excludes row 8
    ev_c[0] = 5; ev_r[0] = 1; ev_c[1] = 6; ev_r[1] = 7; ev_c[2] = 6; ev_r[2] = 8;
    run("R3 low edge", 3, 0);
    // R3: high-edge clamp and column limit at +20 / +21
    ev_c[0] = 200; ev_r[0] = 254; ev_c[1] = 220; ev_r[1] = 248; ev_c[2] = 221; ev_r[2] = 249;
    run("R3 high edge", 3, 0);
    // R4: out-of-window hits keep order for a later window
    ev_c[0] = 30; ev_r[0] = 30; ev_c[1] = 90; ev_r[1] = 30; ev_c[2] = 31; ev_r[2] = 31;
    ev_c[3] = 91; ev_r[3] = 31; ev_c[4] = 30; ev_r[4] = 80;
    run("R4 requeue", 5, 0);
    // R6: anchor first, then lowest remaining index
    ev_c[0] = 10; ev_r[0] = 5; ev_c[1] = 12; ev_r[1] = 2; ev_c[2] = 10; ev_r[2] = 2;
    run("R6 seed order", 3, 0);

    for (int e = 0; e < 40; e++) begin
      int n, cb, rb, c, r;
      n  = 1 + int'($urandom % DEPTH);
      cb = int'($urandom % 240);
      case ($urandom % 3)
        0: rb = 0;
        1: rb = 244;
        default: rb = int'($urandom % 240);
      endcase
      for (int i = 0; i < n; i++) begin
        do begin
          c = cb + int'($urandom % 28); if (c > 255) c = 255;
          r = rb + int'($urandom % 12);
        end while (dup(i, c, r));
        ev_c[i] = c; ev_r[i] = r;
      end
      run("R7 random", n, 0);
    end

    // R2: a full queue without end-of-event stalls input
    for (int i = 0; i < DEPTH; i++) begin ev_c[i] = 3 * i; ev_r[i] = 9; end
    send(DEPTH, 1'b0);
    chk(!in_ready, "R2", "in_ready with full queue", int'(in_ready), 0);
    chk(!out_valid, "R2", "no output before end-of-event", int'(out_valid), 0);
    do_reset();
    chk(in_ready, "R1", "in_ready after second reset", int'(in_ready), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule